// File: doc/BRIEF.md
# Zone-Based Stride Prefetch Detector

This block sits on the miss-address stream of the last cache level and looks for constant strides inside fixed-size regions of memory. No instruction address is needed. The upper bits of each address form a zone tag. The tag selects an entry in a small, fully associative filter table. Each entry keeps the last line seen in its zone, the last stride and a training state.

Once the same nonzero stride has been seen twice in a row within a zone, the block emits a burst of prefetch line addresses: base plus one stride, base plus two strides, and so on, up to a degree set at run time. The burst goes out through a valid/ready port. While a burst is pending, the training input is stalled.

Only shared reads train the table. The cache controller also feeds hits on prefetched-but-unused lines in as shared reads. Exclusive reads are accepted and dropped.

Top module: `zone_stride_prefetch`

## Requirements
- R1: Out of synchronous reset, `pf_valid` is 0 and `miss_ready` is 1, and every table entry is empty.
- R2: Byte addresses are 32 bits wide. The line number is bits [31:6], so bits [5:0] of `miss_addr` have no effect. The zone tag is bits [31:20], and two addresses share an entry only when these bits match.
- R3: The first shared read to a zone allocates an entry holding its line with a cleared stride. The second records the line difference as the stride. A third read that repeats that nonzero stride triggers a burst on the next cycle.
- R4: A burst from trigger line a with stride s and latched degree d presents (a+s)·64, (a+2s)·64, … (a+d·s)·64 in that order. It moves to the next address only on a cycle where `pf_valid` and `pf_ready` are both high, and the low 6 bits of `pf_addr` are always zero.
- R5: With `degree` equal to 0 at the triggering read, no burst starts. The read still trains the entry.
- R6: `miss_ready` is low exactly while `pf_valid` is high. While `pf_ready` is low, `pf_valid` and `pf_addr` hold.
- R7: A read with `miss_shared` = 0 (exclusive) is accepted but changes no entry, including its recency. So it neither starts a burst nor disturbs a training sequence.
- R8: In a trained or confirmed entry, a differing nonzero stride replaces the stored stride and returns the entry to the stride-seen state. The next read that repeats the new stride triggers.
- R9: A burst ends early, after the last address still inside the trigger zone, when the next generated address falls into another zone. If even a+s leaves the zone, no burst starts.
- R10: The table holds 16 zones with least-recently-used replacement, where any shared read to a zone counts as use. A 17th zone evicts the least recently used one, which must then train again from its first read.
- R11: A shared read to the same line as the stored one changes nothing in the entry except its recency.
- R12: Strides are signed. Descending streams train and prefetch with decreasing addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| miss_valid | input | 1 | Training request present |
| miss_ready | output | 1 | Training request accepted this cycle when high |
| miss_addr | input | 32 | Byte address of the miss or prefetched-line hit |
| miss_shared | input | 1 | 1 = shared read (trains), 0 = exclusive read (ignored) |
| degree | input | 4 | Prefetch depth 0..15, sampled at the trigger |
| pf_valid | output | 1 | Prefetch address present |
| pf_ready | input | 1 | Consumer takes the prefetch address |
| pf_addr | output | 32 | Line-aligned prefetch byte address |

## Verification
The hardest cases to reach are those where training state meets replacement and zone edges. One is an evicted zone retraining while other zones keep their confirmed strides. Another is a burst that runs off the top of its zone partway through.

Directed phases build each of these on purpose. Seventeen distinct zones are walked to force an eviction. Streams are started just below a zone boundary so a burst is cut after one address. Back-pressure on `pf_ready` is held while new reads wait.

A long mixed phase then interleaves four zones with changing signed strides, exclusive reads, gaps, random degrees and random back-pressure. A behavioural model with a recency-ordered queue is checked against the outputs on every cycle.

// File: rtl/zsp_pkg.sv
package zsp_pkg;
  typedef enum logic [1:0] {
    ST_EMPTY  = 2'd0,
    ST_FIRST  = 2'd1,
    ST_STRIDE = 2'd2,
    ST_LOCKED = 2'd3
  } zsp_state_e;
endpackage

// File: rtl/zsp_filter_table.sv
module zsp_filter_table
  import zsp_pkg::*;
#(
  parameter int LA_W      = 26,
  parameter int ZONE_BITS = 12,
  parameter int ENTRIES   = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            upd,
  input  logic [LA_W-1:0] line_in,
  output logic            trig,
  output logic [LA_W-1:0] trig_stride
);
  localparam int IDX_W = $clog2(ENTRIES);

  zsp_state_e            st_q   [ENTRIES];
  logic [ZONE_BITS-1:0]  tag_q  [ENTRIES];
  logic [LA_W-1:0]       last_q [ENTRIES];
  logic [LA_W-1:0]       strd_q [ENTRIES];
  logic [IDX_W-1:0]      age_q  [ENTRIES];

  logic [ENTRIES-1:0]    hit_vec;
  logic [ZONE_BITS-1:0]  tag_in;
  logic [IDX_W-1:0]      hit_idx, vic_idx, sel;
  logic                  hit_any;
  logic [LA_W-1:0]       diff;
  zsp_state_e            hit_st;

  assign tag_in = line_in[LA_W-1 -: ZONE_BITS];

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign hit_vec[g] = (st_q[g] != ST_EMPTY) && (tag_q[g] == tag_in);
  end

  always_comb begin
    hit_idx = '0;
    vic_idx = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (hit_vec[i]) hit_idx = IDX_W'(i);
      if (age_q[i] == IDX_W'(ENTRIES - 1)) vic_idx = IDX_W'(i);
    end
  end

  assign hit_any     = |hit_vec;
  assign sel         = hit_any ? hit_idx : vic_idx;
  assign hit_st      = st_q[hit_idx];
  assign diff        = line_in - last_q[hit_idx];
  assign trig        = upd && hit_any && (diff != '0) &&
                       ((hit_st == ST_STRIDE) || (hit_st == ST_LOCKED)) &&
                       (diff == strd_q[hit_idx]);
  assign trig_stride = diff;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < ENTRIES; i++) begin
        st_q[i]   <= ST_EMPTY;
        tag_q[i]  <= '0;
        last_q[i] <= '0;
        strd_q[i] <= '0;
        age_q[i]  <= IDX_W'(ENTRIES - 1 - i);
      end
    end else if (upd) begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (IDX_W'(i) == sel)             age_q[i] <= '0;
        else if (age_q[i] < age_q[sel])   age_q[i] <= age_q[i] + 1'b1;
      end
      if (!hit_any) begin
        st_q[sel]   <= ST_FIRST;
        tag_q[sel]  <= tag_in;
        last_q[sel] <= line_in;
        strd_q[sel] <= '0;
      end else if (diff != '0) begin
        last_q[sel] <= line_in;
        if (hit_st == ST_FIRST || diff != strd_q[sel]) begin
          strd_q[sel] <= diff;
          st_q[sel]   <= ST_STRIDE;
        end else begin
          st_q[sel]   <= ST_LOCKED;
        end
      end
    end
  end
endmodule

// File: rtl/zsp_burst_gen.sv
module zsp_burst_gen #(
  parameter int LA_W      = 26,
  parameter int ZONE_BITS = 12,
  parameter int DEG_W     = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [LA_W-1:0]  base,
  input  logic [LA_W-1:0]  stride,
  input  logic [DEG_W-1:0] degree,
  input  logic             pf_ready,
  output logic             pf_valid,
  output logic [LA_W-1:0]  pf_line
);
  logic [LA_W-1:0]      cur_q, step_q, first, nxt;
  logic [DEG_W-1:0]     rem_q;
  logic [ZONE_BITS-1:0] zone_q;

  assign first   = base + stride;
  assign nxt     = cur_q + step_q;
  assign pf_line = cur_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pf_valid <= 1'b0;
      cur_q    <= '0;
      step_q   <= '0;
      rem_q    <= '0;
      zone_q   <= '0;
    end else if (start && degree != '0 &&
                 first[LA_W-1 -: ZONE_BITS] == base[LA_W-1 -: ZONE_BITS]) begin
      pf_valid <= 1'b1;
      cur_q    <= first;
      step_q   <= stride;
      rem_q    <= degree - 1'b1;
      zone_q   <= base[LA_W-1 -: ZONE_BITS];
    end else if (pf_valid && pf_ready) begin
      if (rem_q == '0 || nxt[LA_W-1 -: ZONE_BITS] != zone_q) begin
        pf_valid <= 1'b0;
      end else begin
        cur_q <= nxt;
        rem_q <= rem_q - 1'b1;
      end
    end
  end
endmodule

// File: rtl/zone_stride_prefetch.sv
module zone_stride_prefetch #(
  parameter int ADDR_W    = 32,
  parameter int LINE_W    = 6,
  parameter int ZONE_BITS = 12,
  parameter int ENTRIES   = 16,
  parameter int DEG_W     = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              miss_valid,
  output logic              miss_ready,
  input  logic [ADDR_W-1:0] miss_addr,
  input  logic              miss_shared,
  input  logic [DEG_W-1:0]  degree,
  output logic              pf_valid,
  input  logic              pf_ready,
  output logic [ADDR_W-1:0] pf_addr
);
  localparam int LA_W = ADDR_W - LINE_W;

  logic            upd, trig;
  logic [LA_W-1:0] line_in, trig_stride, pf_line;

  assign line_in    = miss_addr[ADDR_W-1:LINE_W];
  assign miss_ready = !pf_valid;
  assign upd        = miss_valid && miss_ready && miss_shared;
  assign pf_addr    = {pf_line, {LINE_W{1'b0}}};

  zsp_filter_table #(.LA_W(LA_W), .ZONE_BITS(ZONE_BITS), .ENTRIES(ENTRIES)) u_table (
    .clk(clk), .rst(rst), .upd(upd), .line_in(line_in),
    .trig(trig), .trig_stride(trig_stride)
  );

  zsp_burst_gen #(.LA_W(LA_W), .ZONE_BITS(ZONE_BITS), .DEG_W(DEG_W)) u_burst (
    .clk(clk), .rst(rst), .start(trig), .base(line_in), .stride(trig_stride),
    .degree(degree), .pf_ready(pf_ready), .pf_valid(pf_valid), .pf_line(pf_line)
  );
endmodule

// File: rtl/zsp_checker.sv
module zsp_checker #(
  parameter int ADDR_W    = 32,
  parameter int LINE_W    = 6,
  parameter int ZONE_BITS = 12,
  parameter int DEG_W     = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              miss_valid,
  input logic              miss_ready,
  input logic              miss_shared,
  input logic [DEG_W-1:0]  degree,
  input logic              pf_valid,
  input logic              pf_ready,
  input logic [ADDR_W-1:0] pf_addr
);
  assert_stall_R6: assert property (@(posedge clk) disable iff (rst)
    pf_valid |-> !miss_ready);

  assert_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (pf_valid && !pf_ready) |=> (pf_valid && $stable(pf_addr)));

  assert_aligned_R4: assert property (@(posedge clk) disable iff (rst)
    pf_valid |-> (pf_addr[LINE_W-1:0] == '0));

  assert_same_zone_R9: assert property (@(posedge clk) disable iff (rst)
    (pf_valid && pf_ready) |=>
      (!pf_valid || pf_addr[ADDR_W-1 -: ZONE_BITS] == $past(pf_addr[ADDR_W-1 -: ZONE_BITS])));

  assert_excl_quiet_R7: assert property (@(posedge clk) disable iff (rst)
    (miss_valid && miss_ready && !miss_shared) |=> !pf_valid);

  assert_deg_zero_R5: assert property (@(posedge clk) disable iff (rst)
    (miss_valid && miss_ready && degree == '0) |=> !pf_valid);
endmodule

bind zone_stride_prefetch zsp_checker #(
  .ADDR_W(ADDR_W), .LINE_W(LINE_W), .ZONE_BITS(ZONE_BITS), .DEG_W(DEG_W)
) i_zsp_checker (
  .clk(clk), .rst(rst), .miss_valid(miss_valid), .miss_ready(miss_ready),
  .miss_shared(miss_shared), .degree(degree), .pf_valid(pf_valid),
  .pf_ready(pf_ready), .pf_addr(pf_addr)
);

// File: tb/test_zone_stride_prefetch.sv
module test_zone_stride_prefetch;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        miss_valid = 1'b0, miss_shared = 1'b0, pf_ready = 1'b0;
  logic [31:0] miss_addr = '0;
  logic [3:0]  degree = '0;
  logic        miss_ready, pf_valid;
  logic [31:0] pf_addr;

  always #5 clk = ~clk;

  zone_stride_prefetch i_zone_stride_prefetch (
    .clk(clk), .rst(rst), .miss_valid(miss_valid), .miss_ready(miss_ready),
    .miss_addr(miss_addr), .miss_shared(miss_shared), .degree(degree),
    .pf_valid(pf_valid), .pf_ready(pf_ready), .pf_addr(pf_addr)
  );

  typedef struct {
    logic [11:0] tag;
    logic [25:0] last;
    logic [25:0] strd;
    int          st;   // 1 first seen, 2 stride seen, 3 confirmed
  } ent_t;

  ent_t        tbl[$];
  logic        exp_valid, exp_ready;
  logic [25:0] b_cur, b_step;
  int          b_rem;
  logic [11:0] b_zone;
  int          vectors = 0, miscompares = 0;
  string       phase = "R1";
  bit          done = 0;
  logic [31:0] rng = 32'h1234_5678;

  task automatic compare();
    vectors++;
    if (pf_valid !== exp_valid || miss_ready !== exp_ready ||
        (exp_valid && pf_addr !== {b_cur, 6'b0})) begin
      miscompares++;
      $display("FAIL %s: got valid=%b ready=%b addr=%h, expected valid=%b ready=%b addr=%h",
               phase, pf_valid, miss_ready, pf_addr, exp_valid, exp_ready, {b_cur, 6'b0});
    end
  endtask

  task automatic model_next(input logic v, input logic [31:0] a, input logic sh,
                            input logic [3:0] d, input logic pr);
    logic        acc, trig;
    logic [25:0] ln, df, first;
    logic [11:0] tg;
    int          idx;
    ent_t        e;
    acc  = v && exp_ready;
    trig = 1'b0;
    ln   = a[31:6];
    tg   = a[31:20];
    df   = '0;
    if (exp_valid && pr) begin
      if (b_rem == 0 || ((b_cur + b_step) >> 14) != 26'(b_zone)) exp_valid = 1'b0;
      else begin b_cur = b_cur + b_step; b_rem--; end
    end
    if (acc && sh) begin
      idx = -1;
      foreach (tbl[i]) if (tbl[i].tag == tg) idx = i;
      if (idx < 0) begin
        if (tbl.size() == 16) void'(tbl.pop_back());
        e.tag = tg; e.last = ln; e.strd = '0; e.st = 1;
      end else begin
        e = tbl[idx];
        tbl.delete(idx);
        df = ln - e.last;
        if (df != 0) begin
          if (e.st >= 2 && df == e.strd) begin trig = 1'b1; e.st = 3; end
          else begin e.strd = df; e.st = 2; end
          e.last = ln;
        end
      end
      tbl.push_front(e);
    end
    if (trig && d != 0) begin
      first = ln + df;
      if (first[25:14] == tg) begin
        exp_valid = 1'b1; b_cur = first; b_step = df; b_rem = int'(d) - 1; b_zone = tg;
      end
    end
    exp_ready = !exp_valid;
  endtask

  task automatic step(input logic v, input logic [31:0] a, input logic sh,
                      input logic [3:0] d, input logic pr);
    @(negedge clk);
    compare();
    miss_valid = v; miss_addr = a; miss_shared = sh; degree = d; pf_ready = pr;
    model_next(v, a, sh, d, pr);
  endtask

  task automatic rd(input logic [31:0] a, input logic [3:0] d);
    step(1'b1, a, 1'b1, d, 1'b1);
  endtask

  task automatic drain(input int n);
    for (int i = 0; i < n; i++) step(1'b0, '0, 1'b0, 4'd0, 1'b1);
  endtask

  function automatic logic [31:0] rnd();
    rng = rng ^ (rng << 13); rng = rng ^ (rng >> 17); rng = rng ^ (rng << 5);
    return rng;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: got no finish, expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    logic [31:0] ptr [4];
    int          sst [4];
    exp_valid = 1'b0; exp_ready = 1'b1; b_cur = '0; b_step = '0; b_rem = 0; b_zone = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    phase = "R1"; drain(2);

    phase = "R3"; rd(32'h0010_0000, 4'd4); rd(32'h0010_0080, 4'd4); drain(1);
    phase = "R4"; rd(32'h0010_0100, 4'd4); drain(6);
    phase = "R6";
    rd(32'h0010_0180, 4'd3);
    for (int i = 0; i < 4; i++) step(1'b1, 32'h0010_0200, 1'b1, 4'd3, 1'b0);
    for (int i = 0; i < 6; i++) step(1'b1, 32'h0010_0200, 1'b1, 4'd3, i[0]);
    drain(4);
    phase = "R8"; rd(32'h0010_0300, 4'd2); rd(32'h0010_0400, 4'd2); rd(32'h0010_0500, 4'd2); drain(4);
    phase = "R12"; rd(32'h0028_0000, 4'd5); rd(32'h0027_FFC0, 4'd5); rd(32'h0027_FF80, 4'd5);
    phase = "R12"; rd(32'h0027_0000, 4'd5); drain(2);
    rd(32'h0028_0000, 4'd5); rd(32'h0027_FFC0, 4'd5); rd(32'h0028_0100, 4'd5);
    rd(32'h0028_00C0, 4'd5); rd(32'h0028_0080, 4'd5); drain(8);
    phase = "R9"; rd(32'h003F_FE00, 4'd8); rd(32'h003F_FE80, 4'd8); rd(32'h003F_FF00, 4'd8); drain(4);
    rd(32'h004F_FD00, 4'd8); rd(32'h004F_FE00, 4'd8); rd(32'h004F_FF00, 4'd8); drain(3);
    phase = "R5"; rd(32'h0060_0000, 4'd0); rd(32'h0060_0040, 4'd0); rd(32'h0060_0080, 4'd0);
    rd(32'h0060_00C0, 4'd2); drain(4);
    phase = "R7"; rd(32'h0070_0000, 4'd3); rd(32'h0070_0100, 4'd3);
    step(1'b1, 32'h0070_0900, 1'b0, 4'd3, 1'b1); step(1'b1, 32'h0070_0200, 1'b0, 4'd3, 1'b1);
    rd(32'h0070_0200, 4'd3); drain(5);
    phase = "R2"; rd(32'h0050_0013, 4'd2); rd(32'h0050_007F, 4'd2); rd(32'h0050_00AA, 4'd2); drain(4);
    phase = "R11"; rd(32'h0090_0000, 4'd2); rd(32'h0090_0080, 4'd2); rd(32'h0090_0080, 4'd2);
    rd(32'h0090_00BF, 4'd2); rd(32'h0090_0100, 4'd2); drain(4);
    phase = "R10";
    rd(32'h0A00_0000, 4'd2); rd(32'h0A00_0040, 4'd2);
    for (int z = 1; z <= 16; z++) rd({12'h0A0 + 12'(z), 20'h0_0000}, 4'd2);
    rd(32'h0A00_0080, 4'd2); drain(2); rd(32'h0A00_00C0, 4'd2); rd(32'h0A00_0100, 4'd2); drain(4);

    phase = "R4";
    for (int z = 0; z < 4; z++) begin ptr[z] = {12'h200 + 12'(z), 20'h8_0000}; sst[z] = z + 1; end
    for (int n = 0; n < 3000; n++) begin
      logic [31:0] r;
      int          z;
      r = rnd();
      z = int'(r[1:0]);
      if (r[7:4] == 4'd0) sst[z] = int'(r[10:8]) - 3;
      ptr[z] = {ptr[z][31:20], ptr[z][19:0] + 20'(sst[z] * 64)};
      step(r[12:11] != 2'b00, ptr[z] | 32'(r[18:13]), r[21:19] != 3'd0, r[25:22], r[27] | r[26]);
    end
    drain(20);
    @(negedge clk); compare();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule